// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block brings an LCD timing-generator chip up and down in the order its supply rails demand. It issues single-byte writes to eight control registers (3-bit address) over a valid/ready write handshake. It times its own millisecond pauses with a counter. At the common-voltage step it hands a byte to an external two-wire DAC transmitter through a start/done handshake. A resume or change request runs the full power-up when the panel is cold. When the panel is already up, the same request only refreshes the phase and resolution registers. A suspend request runs the power-down.

The sequence is a fixed table of steps. A state machine walks that table. Its states are IDLE, STEP, WR, TMR, DAC_GO and DAC_WAIT:

- IDLE to STEP on an accepted request.
- STEP to WR, TMR or DAC_GO, by the kind of the current step.
- STEP to IDLE on an end step, which also updates the initialized flag.
- WR to STEP when the write is accepted.
- TMR to STEP when the timer expires.
- DAC_GO to DAC_WAIT unconditionally.
- DAC_WAIT to STEP on the DAC's done pulse.

Mode and trim inputs are captured when a request is taken. The wait lengths in milliseconds and the clocks per millisecond are parameters.

Top module: `lcd_pwr_seq`

## Requirements
- R1: After reset, busy, initialized, wr_valid and dac_start are all 0.
- R2: An init request while not initialized produces exactly these writes, as (address, hex data): (6,1F) (3,03) (4,00) (4,04) (3,07) (6,09) (3,17) (4,06) (6,01) (3,1F) (4,07) (6,00) (1,phase) (7,00) (0,resolution). Address 3 bits are: 0x01 serial clock idle, 0x02 serial data idle, 0x04 DAC, 0x08 COM, 0x10 VCC5. Address 4 bits are: 0x01 VW, 0x02 GVSS, 0x04 VDD. Address 6 bits are: 0x01 init-state, 0x02 init-off, 0x04 power-down, 0x08 COM-signal-off, 0x10 DAC-signal-off.
- R3: In power-up, three pauses are held before a write is presented. They come before the 5th write (3 ms), before the 9th write (2 ms) and before the 15th write (1 ms). Each millisecond lasts CLKS_PER_MS clocks, and each pause ends within 5 clocks of its nominal length.
- R4: In power-up, one DAC transfer is started after the 6th write, carrying com_trim if com_trim_valid, else 125. dac_start is a single-cycle pulse and is never high together with wr_valid. No further write is presented until dac_done.
- R5: The phase byte is 0x13 in QVGA mode (vga_mode=0). In VGA mode it is (phase_trim<<1)|1 when phase_trim_valid, else 0x01.
- R6: The resolution byte, written last to address 0, is 0x00 in VGA mode and 0x01 in QVGA mode.
- R7: An init request while initialized writes only (1,phase) then (0,resolution), starts no DAC transfer and holds no pause.
- R8: A suspend request first holds 34 ms, then writes (4,06) (6,08) (3,14) (4,04) (3,04) (6,1E) (3,00) (4,00). It starts one DAC transfer carrying 0 after the 3rd of those writes, then clears initialized.
- R9: Requests are taken only in IDLE; any request while busy has no effect. When both are raised together, suspend wins.
- R10: While wr_valid is high without wr_ready, wr_valid, wr_addr and wr_data hold. Each accepted write is presented once.
- R11: busy rises the cycle after a request is taken and falls when the sequence ends. initialized rises as a power-up ends.
- R12: vga_mode, phase_trim, phase_trim_valid, com_trim and com_trim_valid are captured when a request is taken. Later changes do not affect the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Resume/change request |
| suspend_req | input | 1 | Power-down request |
| vga_mode | input | 1 | 1 = VGA, 0 = QVGA |
| phase_trim | input | 4 | Phase adjust trim |
| phase_trim_valid | input | 1 | phase_trim is usable |
| com_trim | input | 8 | Common-voltage trim |
| com_trim_valid | input | 1 | com_trim is usable |
| wr_valid | output | 1 | Register write presented |
| wr_ready | input | 1 | Register write accepted |
| wr_addr | output | 3 | Register address |
| wr_data | output | 8 | Register data |
| dac_start | output | 1 | Start pulse to DAC transmitter |
| dac_value | output | 8 | Byte for the DAC |
| dac_done | input | 1 | DAC transfer finished |
| busy | output | 1 | A sequence is running |
| initialized | output | 1 | Panel is powered up |

## Verification
Power-up is exercised from cold in three ways: QVGA with no trims, VGA with both trims, and VGA with no phase trim. Between them they separate the fixed QVGA phase, the trimmed VGA phase, the untrimmed VGA phase and the default common voltage against a supplied one. A repeated init while powered tells the short path from a full restart. Suspend alone, and suspend raised together with init, test the power-down order and the request priority. Inputs are changed, and both requests pulsed, in the middle of a run to show that capture and busy-lockout hold. Write acceptance is delayed by 0 to 3 cycles so that held or duplicated writes show up in the log, and the gaps before writes are measured against the nominal pauses.

// File: rtl/lcd_pwr_pkg.sv
package lcd_pwr_pkg;

    localparam int REG_AW = 3;
    localparam int REG_DW = 8;
    localparam int STEP_W = 5;

    typedef enum logic [1:0] {K_WR, K_WAIT, K_DAC, K_END} step_kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_STEP, S_WR, S_TMR, S_DAC_GO, S_DAC_WAIT
    } seq_state_e;

    // target register addresses (decoded by the panel controller)
    localparam logic [REG_AW-1:0] RA_RES   = 3'd0;
    localparam logic [REG_AW-1:0] RA_PHASE = 3'd1;
    localparam logic [REG_AW-1:0] RA_PWR_A = 3'd3;
    localparam logic [REG_AW-1:0] RA_PWR_B = 3'd4;
    localparam logic [REG_AW-1:0] RA_PIC   = 3'd6;
    localparam logic [REG_AW-1:0] RA_POL   = 3'd7;

    // supply group A
    localparam logic [REG_DW-1:0] PA_SCK = 8'h01;
    localparam logic [REG_DW-1:0] PA_SDA = 8'h02;
    localparam logic [REG_DW-1:0] PA_DAC = 8'h04;
    localparam logic [REG_DW-1:0] PA_COM = 8'h08;
    localparam logic [REG_DW-1:0] PA_V5  = 8'h10;
    // supply group B
    localparam logic [REG_DW-1:0] PB_VW  = 8'h01;
    localparam logic [REG_DW-1:0] PB_GN  = 8'h02;
    localparam logic [REG_DW-1:0] PB_VDD = 8'h04;
    // picture control
    localparam logic [REG_DW-1:0] PC_INIT   = 8'h01;
    localparam logic [REG_DW-1:0] PC_INIOFF = 8'h02;
    localparam logic [REG_DW-1:0] PC_PDWN   = 8'h04;
    localparam logic [REG_DW-1:0] PC_COMOFF = 8'h08;
    localparam logic [REG_DW-1:0] PC_DACOFF = 8'h10;

    // step table landmarks
    localparam logic [STEP_W-1:0] SX_UP_FIRST = 5'd0;
    localparam logic [STEP_W-1:0] SX_PHASE    = 5'd15;
    localparam logic [STEP_W-1:0] SX_RES      = 5'd18;
    localparam logic [STEP_W-1:0] SX_UP_END   = 5'd19;
    localparam logic [STEP_W-1:0] SX_DN_FIRST = 5'd20;
    localparam logic [STEP_W-1:0] SX_DN_END   = 5'd30;

endpackage

// File: rtl/lcd_ms_timer.sv
module lcd_ms_timer #(
    parameter int CLKS_PER_MS = 12500,
    parameter int MSW         = 6,
    parameter int CW          = 20
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [MSW-1:0] ms,
    output logic           done
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(ms) * CW'(CLKS_PER_MS);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == CW'(1));

endmodule

// File: rtl/lcd_seq_rom.sv
module lcd_seq_rom
    import lcd_pwr_pkg::*;
#(
    parameter int VDD_MS      = 3,
    parameter int GVSS_MS     = 2,
    parameter int POL_MS      = 1,
    parameter int SETTLE_MS   = 34,
    parameter int COM_DEFAULT = 125,
    parameter int QVGA_PHASE  = 9,
    parameter int MSW         = 6
) (
    input  logic [STEP_W-1:0] step,
    input  logic              vga,
    input  logic              ph_ok,
    input  logic [3:0]        ph_trim,
    input  logic              com_ok,
    input  logic [REG_DW-1:0] com_trim,
    output step_kind_e        kind,
    output logic [REG_AW-1:0] addr,
    output logic [REG_DW-1:0] data,
    output logic [MSW-1:0]    ms
);

    logic [REG_DW-1:0] phase_byte;
    logic [REG_DW-1:0] res_byte;
    logic [REG_DW-1:0] com_byte;

    always_comb begin
        if (!vga)       phase_byte = {REG_DW'(QVGA_PHASE) << 1} | 8'h01;
        else if (ph_ok) phase_byte = {3'b000, ph_trim, 1'b1};
        else            phase_byte = 8'h01;
        res_byte = vga ? 8'h00 : 8'h01;
        com_byte = com_ok ? com_trim : REG_DW'(COM_DEFAULT);
    end

    always_comb begin
        kind = K_WR;
        addr = '0;
        data = '0;
        ms   = '0;
        case (step)
            // power-up
            5'd0:  begin addr = RA_PIC;   data = PC_PDWN | PC_INIOFF | PC_INIT | PC_COMOFF | PC_DACOFF; end
            5'd1:  begin addr = RA_PWR_A; data = PA_SCK | PA_SDA; end
            5'd2:  begin addr = RA_PWR_B; data = 8'h00; end
            5'd3:  begin addr = RA_PWR_B; data = PB_VDD; end
            5'd4:  begin kind = K_WAIT;   ms = MSW'(VDD_MS); end
            5'd5:  begin addr = RA_PWR_A; data = PA_SCK | PA_SDA | PA_DAC; end
            5'd6:  begin addr = RA_PIC;   data = PC_INIT | PC_COMOFF; end
            5'd7:  begin kind = K_DAC;    data = com_byte; end
            5'd8:  begin addr = RA_PWR_A; data = PA_SCK | PA_SDA | PA_DAC | PA_V5; end
            5'd9:  begin addr = RA_PWR_B; data = PB_GN | PB_VDD; end
            5'd10: begin kind = K_WAIT;   ms = MSW'(GVSS_MS); end
            5'd11: begin addr = RA_PIC;   data = PC_INIT; end
            5'd12: begin addr = RA_PWR_A; data = PA_SCK | PA_SDA | PA_DAC | PA_COM | PA_V5; end
            5'd13: begin addr = RA_PWR_B; data = PB_VW | PB_GN | PB_VDD; end
            5'd14: begin addr = RA_PIC;   data = 8'h00; end
            5'd15: begin addr = RA_PHASE; data = phase_byte; end
            5'd16: begin addr = RA_POL;   data = 8'h00; end
            5'd17: begin kind = K_WAIT;   ms = MSW'(POL_MS); end
            5'd18: begin addr = RA_RES;   data = res_byte; end
            // power-down
            5'd20: begin kind = K_WAIT;   ms = MSW'(SETTLE_MS); end
            5'd21: begin addr = RA_PWR_B; data = PB_GN | PB_VDD; end
            5'd22: begin addr = RA_PIC;   data = PC_COMOFF; end
            5'd23: begin addr = RA_PWR_A; data = PA_DAC | PA_V5; end
            5'd24: begin kind = K_DAC;    data = 8'h00; end
            5'd25: begin addr = RA_PWR_B; data = PB_VDD; end
            5'd26: begin addr = RA_PWR_A; data = PA_DAC; end
            5'd27: begin addr = RA_PIC;   data = PC_INIOFF | PC_DACOFF | PC_PDWN | PC_COMOFF; end
            5'd28: begin addr = RA_PWR_A; data = 8'h00; end
            5'd29: begin addr = RA_PWR_B; data = 8'h00; end
            default: kind = K_END;
        endcase
    end

endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
    import lcd_pwr_pkg::*;
#(
    parameter int CLKS_PER_MS = 12500,
    parameter int VDD_MS      = 3,
    parameter int GVSS_MS     = 2,
    parameter int POL_MS      = 1,
    parameter int SETTLE_MS   = 34,
    parameter int COM_DEFAULT = 125,
    parameter int QVGA_PHASE  = 9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init_req,
    input  logic        suspend_req,
    input  logic        vga_mode,
    input  logic [3:0]  phase_trim,
    input  logic        phase_trim_valid,
    input  logic [7:0]  com_trim,
    input  logic        com_trim_valid,
    output logic        wr_valid,
    input  logic        wr_ready,
    output logic [2:0]  wr_addr,
    output logic [7:0]  wr_data,
    output logic        dac_start,
    output logic [7:0]  dac_value,
    input  logic        dac_done,
    output logic        busy,
    output logic        initialized
);

    localparam int MAX_A  = (VDD_MS > GVSS_MS) ? VDD_MS : GVSS_MS;
    localparam int MAX_B  = (POL_MS > SETTLE_MS) ? POL_MS : SETTLE_MS;
    localparam int MAX_MS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MSW    = $clog2(MAX_MS + 1);
    localparam int CW     = $clog2(MAX_MS * CLKS_PER_MS + 1);

    seq_state_e        state_q, state_n;
    logic [STEP_W-1:0] step_q, step_n, step_inc;
    logic              short_q, short_n;
    logic              take, take_dn;
    logic              vga_q, ph_ok_q, com_ok_q;
    logic [3:0]        ph_q;
    logic [7:0]        com_q;
    logic              init_set, init_clr;

    step_kind_e        kind;
    logic [REG_AW-1:0] rom_addr;
    logic [REG_DW-1:0] rom_data;
    logic [MSW-1:0]    rom_ms;
    logic              tmr_load, tmr_done;

    lcd_seq_rom #(
        .VDD_MS(VDD_MS), .GVSS_MS(GVSS_MS), .POL_MS(POL_MS),
        .SETTLE_MS(SETTLE_MS), .COM_DEFAULT(COM_DEFAULT),
        .QVGA_PHASE(QVGA_PHASE), .MSW(MSW)
    ) i_rom (
        .step(step_q), .vga(vga_q), .ph_ok(ph_ok_q), .ph_trim(ph_q),
        .com_ok(com_ok_q), .com_trim(com_q),
        .kind(kind), .addr(rom_addr), .data(rom_data), .ms(rom_ms)
    );

    lcd_ms_timer #(
        .CLKS_PER_MS(CLKS_PER_MS), .MSW(MSW), .CW(CW)
    ) i_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .ms(rom_ms), .done(tmr_done)
    );

    // the short path hops from the phase write straight to the resolution write
    assign step_inc = (short_q && step_q == SX_PHASE) ? SX_RES : step_q + 1'b1;

    // next-state and step bookkeeping
    always_comb begin
        state_n  = state_q;
        step_n   = step_q;
        short_n  = short_q;
        take     = 1'b0;
        take_dn  = 1'b0;
        init_set = 1'b0;
        init_clr = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (suspend_req) begin
                    take    = 1'b1;
                    take_dn = 1'b1;
                    step_n  = SX_DN_FIRST;
                    short_n = 1'b0;
                    state_n = S_STEP;
                end else if (init_req) begin
                    take    = 1'b1;
                    step_n  = initialized ? SX_PHASE : SX_UP_FIRST;
                    short_n = initialized;
                    state_n = S_STEP;
                end
            end
            S_STEP: begin
                unique case (kind)
                    K_WR:   state_n = S_WR;
                    K_WAIT: state_n = S_TMR;
                    K_DAC:  state_n = S_DAC_GO;
                    K_END: begin
                        state_n  = S_IDLE;
                        init_set = (step_q == SX_UP_END);
                        init_clr = (step_q == SX_DN_END);
                    end
                endcase
            end
            S_WR: begin
                if (wr_ready) begin
                    step_n  = step_inc;
                    state_n = S_STEP;
                end
            end
            S_TMR: begin
                if (tmr_done) begin
                    step_n  = step_inc;
                    state_n = S_STEP;
                end
            end
            S_DAC_GO: state_n = S_DAC_WAIT;
            S_DAC_WAIT: begin
                if (dac_done) begin
                    step_n  = step_inc;
                    state_n = S_STEP;
                end
            end
            default: state_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    // step pointer, captured request context and panel status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q      <= '0;
            short_q     <= 1'b0;
            vga_q       <= 1'b0;
            ph_ok_q     <= 1'b0;
            ph_q        <= '0;
            com_ok_q    <= 1'b0;
            com_q       <= '0;
            initialized <= 1'b0;
        end else begin
            step_q  <= step_n;
            short_q <= short_n;
            if (take && !take_dn) begin
                vga_q    <= vga_mode;
                ph_ok_q  <= phase_trim_valid;
                ph_q     <= phase_trim;
                com_ok_q <= com_trim_valid;
                com_q    <= com_trim;
            end
            if (init_set)      initialized <= 1'b1;
            else if (init_clr) initialized <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        tmr_load  = (state_q == S_STEP) && (kind == K_WAIT);
        wr_valid  = (state_q == S_WR);
        wr_addr   = rom_addr;
        wr_data   = rom_data;
        dac_start = (state_q == S_DAC_GO);
        dac_value = rom_data;
        busy      = (state_q != S_IDLE);
    end

endmodule

// File: rtl/lcd_pwr_seq_chk.sv
module lcd_pwr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       init_req,
    input logic       suspend_req,
    input logic       wr_valid,
    input logic       wr_ready,
    input logic [2:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       dac_start,
    input logic       busy,
    input logic       initialized
);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_valid && !dac_start);

    p_dac_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dac_start |=> !dac_start);

    p_dac_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(dac_start && wr_valid));

    p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(init_req || suspend_req));

    p_init_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(initialized) |-> !busy && $past(busy));

    p_init_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(initialized) |-> !busy && $past(busy));

endmodule

bind lcd_pwr_seq lcd_pwr_seq_chk i_chk (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .suspend_req(suspend_req),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .dac_start(dac_start), .busy(busy), .initialized(initialized)
);

// File: tb/test_lcd_pwr_seq.sv
`timescale 1ns/1ps
module test_lcd_pwr_seq;

    localparam int CPM = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_req = 1'b0, suspend_req = 1'b0, vga_mode = 1'b0;
    logic [3:0] phase_trim = '0;
    logic       phase_trim_valid = 1'b0;
    logic [7:0] com_trim = '0;
    logic       com_trim_valid = 1'b0;
    logic       wr_valid, wr_ready = 1'b0;
    logic [2:0] wr_addr;
    logic [7:0] wr_data, dac_value;
    logic       dac_start, dac_done = 1'b0, busy, initialized;

    lcd_pwr_seq #(.CLKS_PER_MS(CPM)) i_lcd_pwr_seq (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .suspend_req(suspend_req),
        .vga_mode(vga_mode), .phase_trim(phase_trim), .phase_trim_valid(phase_trim_valid),
        .com_trim(com_trim), .com_trim_valid(com_trim_valid),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .dac_start(dac_start), .dac_value(dac_value), .dac_done(dac_done),
        .busy(busy), .initialized(initialized)
    );

    always #2.5 clk = ~clk;

    int nchk = 0, nerr = 0, cyc = 0;
    bit finished = 0;

    // write / DAC log
    int lg_a[40], lg_d[40], lg_first[40], lg_acc[40];
    int n = 0, dac_n = 0, dac_v = 0, dac_wr_at = 0, hold_bad = 0, req_cyc = 0;
    int exp_a[40], exp_d[40], exp_n = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    initial forever begin @(posedge clk); cyc++; end

    // register write and DAC responders
    initial begin
        bit seen = 0;
        int wcnt = 0, dly = 0, dcnt = 0, ha = 0, hd = 0, first = 0;
        forever begin
            @(negedge clk);
            if (wr_ready) wr_ready = 1'b0;
            else if (wr_valid) begin
                if (!seen) begin
                    seen = 1; wcnt = 0; first = cyc; ha = wr_addr; hd = wr_data;
                end else if (ha != wr_addr || hd != wr_data) hold_bad++;
                if (wcnt >= dly) begin
                    if (n < 40) begin
                        lg_a[n] = wr_addr; lg_d[n] = wr_data;
                        lg_first[n] = first; lg_acc[n] = cyc;
                    end
                    n++;
                    wr_ready = 1'b1; seen = 0; dly = n % 4;
                end else wcnt++;
            end
            if (dac_done) dac_done = 1'b0;
            else if (dcnt > 0) begin
                dcnt--;
                if (dcnt == 0) begin dac_done = 1'b1; dac_wr_at = n; end
            end
            if (dac_start) begin dac_n++; dac_v = dac_value; dcnt = 5; end
        end
    end

    task automatic clear_log();
        n = 0; dac_n = 0; dac_v = -1; dac_wr_at = -1; hold_bad = 0;
    endtask

    task automatic put(input int a, input int d);
        exp_a[exp_n] = a; exp_d[exp_n] = d; exp_n++;
    endtask

    task automatic build_up(input bit vga, input bit pok, input int pt);
        int ph;
        ph = !vga ? 8'h13 : (pok ? ((pt << 1) | 1) : 1);
        exp_n = 0;
        put(6,'h1F); put(3,'h03); put(4,'h00); put(4,'h04); put(3,'h07);
        put(6,'h09); put(3,'h17); put(4,'h06); put(6,'h01); put(3,'h1F);
        put(4,'h07); put(6,'h00); put(1,ph);   put(7,'h00); put(0, vga ? 0 : 1);
    endtask

    task automatic build_dn();
        exp_n = 0;
        put(4,'h06); put(6,'h08); put(3,'h14); put(4,'h04);
        put(3,'h04); put(6,'h1E); put(3,'h00); put(4,'h00);
    endtask

    task automatic cmp_seq(input string req);
        chk(n == exp_n, req, "write count", n, exp_n);
        for (int i = 0; i < exp_n && i < n; i++) begin
            chk(lg_a[i] == exp_a[i], req, $sformatf("addr of write %0d", i), lg_a[i], exp_a[i]);
            chk(lg_d[i] == exp_d[i], req, $sformatf("data of write %0d", i), lg_d[i], exp_d[i]);
        end
        chk(hold_bad == 0, "R10", "write changed while held", hold_bad, 0);
    endtask

    task automatic chk_gap(input int idx, input int ms, input int from_cyc);
        int g;
        g = lg_first[idx] - from_cyc;
        chk(g >= ms*CPM + 1 && g <= ms*CPM + 5, "R3",
            $sformatf("pause before write %0d", idx), g, ms*CPM + 3);
    endtask

    task automatic pulse(input bit ini, input bit sus);
        @(negedge clk);
        init_req = ini; suspend_req = sus; req_cyc = cyc;
        @(negedge clk);
        init_req = 1'b0; suspend_req = 1'b0;
    endtask

    task automatic wait_idle(output int t);
        t = 0;
        while (busy && t < 5000) begin @(negedge clk); t++; end
        chk(t < 5000, "R11", "sequence did not end", t, 0);
    endtask

    task automatic t_reset();
        chk(!busy && !initialized, "R1", "busy/initialized after reset", {busy, initialized}, 0);
        chk(!wr_valid && !dac_start, "R1", "wr_valid/dac_start after reset", {wr_valid, dac_start}, 0);
    endtask

    task automatic t_up_qvga();
        int t;
        clear_log();
        vga_mode = 0; phase_trim_valid = 0; com_trim_valid = 0;
        pulse(1, 0);
        chk(busy == 1'b1, "R11", "busy after request", busy, 1);
        wait_idle(t);
        build_up(0, 0, 0);
        cmp_seq("R2/R5/R6");
        chk(dac_n == 1 && dac_v == 125, "R4", "default common voltage", dac_v, 125);
        chk(dac_wr_at == 6, "R4", "writes before dac_done", dac_wr_at, 6);
        if (n >= 15) begin
            chk_gap(4, 3, lg_acc[3]);
            chk_gap(8, 2, lg_acc[7]);
            chk_gap(14, 1, lg_acc[13]);
        end
        chk(initialized == 1'b1, "R11", "initialized after power-up", initialized, 1);
    endtask

    task automatic t_repeat_init();
        int t;
        clear_log();
        vga_mode = 1; phase_trim_valid = 0;
        pulse(1, 0);
        wait_idle(t);
        exp_n = 0; put(1, 'h01); put(0, 'h00);
        cmp_seq("R7");
        chk(dac_n == 0, "R7", "DAC transfers on short path", dac_n, 0);
        chk(t < 30, "R7", "short path length", t, 0);
        chk(initialized == 1'b1, "R7", "initialized kept", initialized, 1);
    endtask

    task automatic t_down(input bit both);
        int t;
        clear_log();
        pulse(both, 1);
        wait_idle(t);
        build_dn();
        cmp_seq(both ? "R9" : "R8");
        chk(dac_n == 1 && dac_v == 0, "R8", "zero common voltage", dac_v, 0);
        chk(dac_wr_at == 3, "R8", "writes before dac_done", dac_wr_at, 3);
        if (n >= 1) chk_gap(0, 34, req_cyc);
        chk(initialized == 1'b0, "R8", "initialized cleared", initialized, 1'b0);
    endtask

    task automatic t_up_vga_busy();
        int t;
        clear_log();
        vga_mode = 1; phase_trim = 4'hA; phase_trim_valid = 1;
        com_trim = 8'h50; com_trim_valid = 1;
        pulse(1, 0);
        repeat (30) @(negedge clk);
        vga_mode = 0; phase_trim = 4'h3; com_trim = 8'h11;
        pulse(1, 1);
        chk(busy == 1'b1, "R9", "still busy after extra requests", busy, 1);
        wait_idle(t);
        build_up(1, 1, 4'hA);
        cmp_seq("R12/R5");
        chk(dac_n == 1 && dac_v == 8'h50, "R12", "captured common voltage", dac_v, 8'h50);
        chk(initialized == 1'b1, "R9", "not powered down by ignored suspend", initialized, 1);
        repeat (40) @(negedge clk);
        chk(n == 15 && !busy, "R9", "writes after idle", n, 15);
    endtask

    task automatic t_up_vga_notrim();
        int t;
        clear_log();
        vga_mode = 1; phase_trim_valid = 0; com_trim_valid = 0;
        pulse(1, 0);
        wait_idle(t);
        build_up(1, 0, 0);
        cmp_seq("R5/R6");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_up_qvga();
        t_repeat_init();
        t_down(0);
        t_up_vga_busy();
        t_down(1);
        t_up_vga_notrim();
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        #(150000 * 5);
        if (!finished) begin
            finished = 1;
            nchk++; nerr++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule